// File: doc/BRIEF.md
# Edge-Reversal Ring Sequencer

This block schedules a ring of worker stages with edge-orientation tokens instead of a shift register. Every pair of neighbouring stages shares one edge, held in a one-bit toggle register. A stage may start work only when it is a sink, that is, when both of its edges point toward it. While it works it holds its `operate` output high. When its worker answers on `done`, the stage flips both of its edges so they point away from it. That flip hands the token to the next stage around the ring.

The design is a clocked version of a self-timed scheme. When `run` is low, every edge is forced to its starting orientation and no stage works. In that orientation each edge points from the higher-indexed stage to the lower one, so stage 0 is the only sink. When `run` goes high, the ring produces a one-hot `operate` pattern. The pattern moves on by one stage for each completed operation and wraps from the last stage back to stage 0.

Top module: `edge_ring_seq`

## Requirements
- R1: While `rst_n` is low, and in the cycle after any cycle in which `run` was sampled low, `operate` is all zero. In both cases every edge is forced to the starting orientation.
- R2: A stage raises `operate` only on the clock edge after a cycle in which it was a sink and `run` was high. After reset with `run` high, stage 0 (`operate` bit 0) is the first stage to work, one clock edge after `run` is sampled high.
- R3: Once raised, `operate[j]` stays high for as long as `done[j]` stays low and `run` stays high.
- R4: `done[j]` takes effect only while `operate[j]` is high. Each accepted `done` reverses the stage's two edges exactly once. A `done` bit for a stage that is not working changes nothing: the order of the sequence stays the same.
- R5: If `done[j]` is high while stage j works, `operate[j]` drops at the next clock edge. Stage (j+1) mod N raises `operate` one clock edge after that, provided `run` stays high.
- R6: After stage N-1 completes, the sequence wraps to stage 0 (`operate` bit 0).
- R7: `operate` is one-hot or zero. Two neighbouring stages, including stage N-1 and stage 0, are never sinks at the same time.
- R8: Dropping `run` in the middle of a sequence aborts it. When `run` is raised again, the sequence restarts at stage 0.
- R9: `N_NODES` is a parameter of at least 3. A smaller value is an elaboration error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run | input | 1 | High lets the ring run; low forces the starting edge orientation |
| done | input | N_NODES | End-of-operation from each stage's worker |
| operate | output | N_NODES | Grant to each stage's worker |

## Verification
On every cycle, the checker tests four properties:
- no two neighbouring stages are sinks together, and `operate` never holds more than one bit;
- a stage starts only from a sink;
- a stage keeps its grant until `done` arrives;
- each completion reverses the edges once and passes the grant to the next stage.

Only the bench's scenarios can show the following:
- the actual order of stages across several laps, including the wrap from the last stage to stage 0;
- that stray or held `done` bits leave that order unchanged;
- that an abort followed by a restart always returns to stage 0.

// File: rtl/ring_seq_pkg.sv
package ring_seq_pkg;

  typedef enum logic {ND_WAIT = 1'b0, ND_BUSY = 1'b1} node_state_e;

  // Index of the neighbour after idx around a ring of n stages.
  function automatic int unsigned ring_next(input int unsigned idx, input int unsigned n);
    return (idx + 1 == n) ? 0 : idx + 1;
  endfunction

  // Index of the neighbour before idx around a ring of n stages.
  function automatic int unsigned ring_prev(input int unsigned idx, input int unsigned n);
    return (idx == 0) ? n - 1 : idx - 1;
  endfunction

  // Starting value of edge k. Edge k joins stage k (low end) and stage
  // ring_next(k) (high end). A value of 1 points the edge at its low end.
  // Each edge points from the higher index to the lower one, so the closing
  // edge (k = n-1) points at its high end, which is stage 0.
  function automatic logic edge_preset(input int unsigned k, input int unsigned n);
    return (k != n - 1) ? 1'b1 : 1'b0;
  endfunction

endpackage

// File: rtl/ring_edge_ctrl.sv
module ring_edge_ctrl #(
  parameter logic PRESET = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic stop,
  input  logic rev_lo,   // low-end stage finished its operation
  input  logic rev_hi,   // high-end stage finished its operation
  output logic tok_lo,   // edge points at the low-end stage
  output logic tok_hi    // edge points at the high-end stage
);
  logic dir_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                dir_q <= PRESET;
    else if (stop)             dir_q <= PRESET;
    else if (rev_lo || rev_hi) dir_q <= ~dir_q;
  end

  assign tok_lo = dir_q;
  assign tok_hi = ~dir_q;
endmodule

// File: rtl/ring_node_ctrl.sv
module ring_node_ctrl
  import ring_seq_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic tok_left,   // edge shared with the previous stage
  input  logic tok_right,  // edge shared with the next stage
  input  logic done,
  output logic operate,
  output logic sink,
  output logic reverse
);
  node_state_e state_q, state_d;

  assign sink    = tok_left && tok_right;
  assign reverse = (state_q == ND_BUSY) && done;

  always_comb begin
    state_d = state_q;
    if (!run)                               state_d = ND_WAIT;
    else if (state_q == ND_WAIT && sink)    state_d = ND_BUSY;
    else if (state_q == ND_BUSY && done)    state_d = ND_WAIT;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ND_WAIT;
    else        state_q <= state_d;
  end

  assign operate = (state_q == ND_BUSY);
endmodule

// File: rtl/edge_ring_seq.sv
module edge_ring_seq
  import ring_seq_pkg::*;
#(
  parameter int unsigned N_NODES = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               run,
  input  logic [N_NODES-1:0] done,
  output logic [N_NODES-1:0] operate
);
  localparam int unsigned N_EDGES = N_NODES;

  if (N_NODES < 3) begin : g_bad_size
    // R9
    $error("edge_ring_seq needs at least three stages");
  end

  logic [N_EDGES-1:0] edge_tok_lo;
  logic [N_EDGES-1:0] edge_tok_hi;
  logic [N_NODES-1:0] sink_vec;
  logic [N_NODES-1:0] rev_vec;
  logic               stop;

  assign stop = !run;

  for (genvar k = 0; k < N_EDGES; k++) begin : g_edge
    localparam int unsigned HI = ring_next(k, N_NODES);
    ring_edge_ctrl #(.PRESET(edge_preset(k, N_NODES))) u_edge (
      .clk    (clk),
      .rst_n  (rst_n),
      .stop   (stop),
      .rev_lo (rev_vec[k]),
      .rev_hi (rev_vec[HI]),
      .tok_lo (edge_tok_lo[k]),
      .tok_hi (edge_tok_hi[k])
    );
  end

  for (genvar j = 0; j < N_NODES; j++) begin : g_node
    localparam int unsigned PV = ring_prev(j, N_NODES);
    ring_node_ctrl u_node (
      .clk       (clk),
      .rst_n     (rst_n),
      .run       (run),
      .tok_left  (edge_tok_hi[PV]),
      .tok_right (edge_tok_lo[j]),
      .done      (done[j]),
      .operate   (operate[j]),
      .sink      (sink_vec[j]),
      .reverse   (rev_vec[j])
    );
  end
endmodule

// File: rtl/edge_ring_seq_chk.sv
module edge_ring_seq_chk
  import ring_seq_pkg::*;
#(
  parameter int unsigned N_NODES = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic               run,
  input logic [N_NODES-1:0] done,
  input logic [N_NODES-1:0] operate,
  input logic [N_NODES-1:0] sink_vec,
  input logic [N_NODES-1:0] rev_vec
);
  // R1
  stop_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (operate == '0));

  // R7
  grant_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(operate));

  for (genvar j = 0; j < N_NODES; j++) begin : g_chk
    localparam int unsigned NX = ring_next(j, N_NODES);

    // R7
    sink_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(sink_vec[j] && sink_vec[NX]));

    // R2
    start_from_sink_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(operate[j]) |-> $past(sink_vec[j] && run));

    // R3
    hold_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (operate[j] && !done[j] && run) |=> operate[j]);

    // R4
    single_rev_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rev_vec[j] |=> (!rev_vec[j] && !operate[j]));

    // R5
    handoff_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rev_vec[j] && run) ##1 run |=> operate[NX]);
  end
endmodule

bind edge_ring_seq edge_ring_seq_chk #(.N_NODES(N_NODES)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .run      (run),
  .done     (done),
  .operate  (operate),
  .sink_vec (sink_vec),
  .rev_vec  (rev_vec)
);

// File: tb/tb_edge_ring_seq.sv
`timescale 1ns/1ps
module tb_edge_ring_seq;
  localparam int N = 5;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         run = 1'b0;
  logic [N-1:0] done = '0;
  logic [N-1:0] operate;

  int checks = 0;
  int fails = 0;
  int cur = 0;
  int cyc = 0;
  bit finished = 1'b0;

  edge_ring_seq #(.N_NODES(N)) dut (
    .clk(clk), .rst_n(rst_n), .run(run), .done(done), .operate(operate)
  );

  always #2 clk = ~clk;

  function automatic logic [N-1:0] onehot(input int idx);
    logic [N-1:0] v;
    v = '0;
    v[idx] = 1'b1;
    return v;
  endfunction

  task automatic check(input string req, input logic [N-1:0] exp);
    checks++;
    if (operate !== exp) begin
      fails++;
      $display("FAIL %s: operate=%b expected=%b", req, operate, exp);
    end
  endtask

  // R7: neighbouring stages never granted together, checked every cycle
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      int bad;
      bad = 0;
      for (int i = 0; i < N; i++)
        if (operate[i] === 1'b1 && operate[(i + 1) % N] === 1'b1) bad = 1;
      checks++;
      if (bad != 0) begin
        fails++;
        $display("FAIL R7: operate=%b expected no adjacent pair", operate);
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000 && !finished) begin
      finished = 1'b1;
      fails++;
      $display("FAIL watchdog: run hung");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  // Serve the active stage: hold for some cycles with stray done bits
  // (R3, R4), release it (R5), then expect the next stage (R5, R6).
  task automatic serve(input int hold, input logic [N-1:0] stray);
    for (int h = 0; h < hold; h++) begin
      done = stray & ~onehot(cur);
      @(negedge clk);
      check("R3 hold", onehot(cur));
    end
    done = onehot(cur) | stray;
    @(negedge clk);
    check("R5 release", '0);
    done = stray;   // R4: done to idle stages in the gap is ignored
    @(negedge clk);
    cur = (cur + 1) % N;
    check(cur == 0 ? "R6 wrap" : "R5 advance", onehot(cur));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset", '0);
    rst_n = 1'b1;
    done = '1;      // R4: ignored while no stage works
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check("R1 run low", '0);
    end
    done = '0;
    run = 1'b1;
    @(negedge clk);
    cur = 0;
    check("R2 first stage", onehot(0));

    for (int lap = 0; lap < 3; lap++)
      for (int n = 0; n < N; n++)
        serve((lap * N + n) % 4,
              lap == 0 ? '0 : N'((lap * 7 + n * 3) % (1 << N)));

    // R4: done for the active stage held over two cycles acts once
    done = onehot(cur);
    @(negedge clk);
    check("R4 held done release", '0);
    @(negedge clk);
    cur = (cur + 1) % N;
    check("R4 held done single step", onehot(cur));
    done = '0;
    @(negedge clk);
    check("R4 held done hold", onehot(cur));

    // R8: abort mid-sequence, restart at stage 0
    serve(1, '0);
    run = 1'b0;
    @(negedge clk);
    check("R8 abort", '0);
    @(negedge clk);
    check("R1 stopped", '0);
    run = 1'b1;
    @(negedge clk);
    cur = 0;
    check("R8 restart", onehot(0));
    serve(0, '0);
    serve(2, '0);

    // R8: abort in the same cycle as a completion
    done = onehot(cur);
    run = 1'b0;
    @(negedge clk);
    check("R8 abort with done", '0);
    done = '0;
    run = 1'b1;
    @(negedge clk);
    cur = 0;
    check("R8 restart after done", onehot(0));
    for (int n = 0; n < N; n++) serve(0, '0);
    check("R6 second wrap", onehot(0));

    finished = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule